// File: doc/BRIEF.md
# Tile-Table Framebuffer Fetch Sequencer

This block turns one display frame into a stream of memory read requests. The frame is stored as 64 KiB tiles scattered in memory. A table of 16-bit pointers, one per tile, gives their locations. On a start pulse the sequencer samples its configuration and walks the table. It first issues a 2-byte read for each table entry and waits for the entry to come back. It then issues the pixel reads for that tile. Each pixel read carries a source address, a byte count and a destination offset in a linear framebuffer. An external mover performs the transfer.

There are two ways to read a tile. In tiled mode the tile is a 512-byte by 128-line rectangle, and the sequencer issues one request per line. Lines are clipped at the right and bottom screen edges. In linear mode the tile is a flat 64 KiB block, read in fixed-size chunks. The final chunk is shortened so the frame ends exactly at width × height × bytes-per-pixel.

The controller has six states:

- `ST_IDLE` waits for a start pulse.
- `ST_TBL_REQ` issues a table-entry read.
- `ST_TBL_WAIT` waits for the entry data.
- `ST_LINE` issues tiled line reads.
- `ST_CHUNK` issues linear chunk reads.
- `ST_FINISH` raises done for one cycle.

The transitions are:

- **start-empty**: `ST_IDLE` to `ST_FINISH`, when the frame has nothing to fetch.
- **start-walk**: `ST_IDLE` to `ST_TBL_REQ`.
- **entry-issued**: `ST_TBL_REQ` to `ST_TBL_WAIT`.
- **entry-tiled**: `ST_TBL_WAIT` to `ST_LINE`.
- **entry-linear**: `ST_TBL_WAIT` to `ST_CHUNK`.
- **next-tile**: `ST_LINE` or `ST_CHUNK` back to `ST_TBL_REQ`.
- **frame-end**: `ST_LINE` or `ST_CHUNK` to `ST_FINISH`.
- **rearm**: `ST_FINISH` to `ST_IDLE`.

Top module: `tile_fetch_seq`

## Requirements
- R1: The table base is `frm_ctrl[31:9]` with the low 9 bits forced to zero. Entry n is requested at base + 2·n with `req_len` = 2 and `req_is_table` = 1. The returned 16-bit entry, shifted left by 16, is the tile address.
- R2: A start with a zero table base, with `frm_ctrl[0]` (fetch enable) clear, or with a zero width or height produces no request. Done is raised in the cycle after start.
- R3: The depth field `plane_ctrl[14:13]` sets the bytes per pixel: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes. A tile row then holds 512, 256 or 128 pixels.
- R4: With `frm_ctrl[1]` = 0 (tiled), line y of a tile at address T is requested at T + 512·y. Its length is pixels × bytes-per-pixel, and its destination is ((ybase + y)·xres + xbase)·bytes-per-pixel.
- R5: In tiled mode, the line count per tile is clipped to yres − ybase (at most 128) and the pixel count to xres − xbase. After each tile, xbase advances by the tile width. Once xbase reaches xres it returns to 0 and ybase grows by 128. The frame ends when ybase reaches yres.
- R6: With `frm_ctrl[1]` = 1 (linear), each tile is read in CHUNK_BYTES pieces at T + offset, for offsets 0 up to 65536 − CHUNK_BYTES. Destination offsets run consecutively from 0 across tiles.
- R7: In linear mode, the chunk that reaches or passes xres·yres·bytes-per-pixel is shortened to end exactly there, and no request follows it.
- R8: A request held without ready keeps `req_valid` and all of its fields unchanged. After reset no request is pending and done is low.
- R9: Done is high for exactly one cycle, the cycle after the final request is accepted. A start pulse during a frame, including in that final cycle, is ignored.
- R10: An `ent_valid` strobe outside the wait for a table entry has no effect on any request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame start pulse, sampled in idle |
| frm_ctrl | input | 32 | Table base [31:9], linear select [1], fetch enable [0] |
| plane_ctrl | input | 32 | Depth field in [14:13] |
| xres | input | XY_W | Screen width in pixels |
| yres | input | XY_W | Screen height in lines |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Request accepted when high with valid |
| req_addr | output | 32 | Source memory address |
| req_len | output | LEN_W | Byte count |
| req_dst | output | 32 | Framebuffer destination offset |
| req_is_table | output | 1 | Request is a table-entry read |
| ent_valid | input | 1 | Table entry data strobe |
| ent_data | input | 16 | Table entry value |
| done | output | 1 | One-cycle frame completion pulse |

## Verification
Two events are forced into the same cycle: acceptance of the frame's final request, and a new start pulse. The bench raises start in exactly the cycle it grants the last request. It then expects a single done pulse in the next cycle and no further requests. Table-entry strobes carrying junk data are also fired at random while no entry is outstanding. Any address that reflects the junk is caught when the following requests are compared with the bench's own model.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TBL_REQ,
        ST_TBL_WAIT,
        ST_LINE,
        ST_CHUNK,
        ST_FINISH
    } tfs_state_e;

    localparam int unsigned TILE_BYTES = 65536;
    localparam int unsigned ROW_BYTES  = 512;
    localparam int unsigned TILE_ROWS  = 128;
endpackage

// File: rtl/tfs_depth_decode.sv
module tfs_depth_decode (
    input  logic [1:0] depth_fld,
    output logic [1:0] bpp_shift,
    output logic [9:0] tile_px
);
    always_comb begin
        bpp_shift = (depth_fld == 2'd3) ? 2'd2 : depth_fld;
        tile_px   = 10'd512 >> bpp_shift;
    end
endmodule

// File: rtl/tfs_clip.sv
module tfs_clip #(
    parameter int DIM_W = 16
) (
    input  logic [DIM_W-1:0] xres,
    input  logic [DIM_W-1:0] yres,
    input  logic [DIM_W-1:0] xbase,
    input  logic [DIM_W-1:0] ybase,
    input  logic [9:0]       tile_px,
    output logic [7:0]       lines,
    output logic [9:0]       pix
);
    logic [DIM_W-1:0] rem_x, rem_y;

    always_comb begin
        rem_x = xres - xbase;
        rem_y = yres - ybase;
        lines = (rem_y < DIM_W'(tfs_pkg::TILE_ROWS)) ? rem_y[7:0] : 8'd128;
        pix   = (rem_x < DIM_W'(tile_px)) ? rem_x[9:0] : tile_px;
    end
endmodule

// File: rtl/tile_fetch_seq.sv
module tile_fetch_seq #(
    parameter int XY_W        = 12,
    parameter int CHUNK_BYTES = 16384,
    parameter int LEN_W       = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      frm_ctrl,
    input  logic [31:0]      plane_ctrl,
    input  logic [XY_W-1:0]  xres,
    input  logic [XY_W-1:0]  yres,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [31:0]      req_addr,
    output logic [LEN_W-1:0] req_len,
    output logic [31:0]      req_dst,
    output logic             req_is_table,
    input  logic             ent_valid,
    input  logic [15:0]      ent_data,
    output logic             done
);
    import tfs_pkg::*;

    localparam int DIM_W = XY_W + 4;
    localparam logic [15:0] LAST_OFF = 16'(TILE_BYTES - CHUNK_BYTES);

    tfs_state_e state_q, state_d;

    logic [31:0]      base_q, tile_addr_q, fb_pos_q, total_q;
    logic             linear_q;
    logic [1:0]       sh_q;
    logic [DIM_W-1:0] xres_q, yres_q, xbase_q, ybase_q;
    logic [15:0]      tile_nr_q, lin_off_q;
    logic [7:0]       line_y_q;

    logic [1:0]       sh_new;
    logic [9:0]       tile_px_new, tile_px;
    logic [7:0]       lines;
    logic [9:0]       pix;
    logic             acc, empty, tile_end, lin_last;
    logic [DIM_W-1:0] nx, ny;
    logic [31:0]      row_idx, pix_idx;

    tfs_depth_decode u_dec_new (
        .depth_fld (plane_ctrl[14:13]),
        .bpp_shift (sh_new),
        .tile_px   (tile_px_new)
    );

    assign tile_px = 10'd512 >> sh_q;

    tfs_clip #(.DIM_W(DIM_W)) u_clip (
        .xres    (xres_q),
        .yres    (yres_q),
        .xbase   (xbase_q),
        .ybase   (ybase_q),
        .tile_px (tile_px),
        .lines   (lines),
        .pix     (pix)
    );

    always_comb begin
        acc      = req_valid && req_ready;
        empty    = (frm_ctrl[31:9] == 23'd0) || !frm_ctrl[0] ||
                   (xres == '0) || (yres == '0);
        tile_end = (line_y_q == lines - 8'd1);
        lin_last = ({1'b0, fb_pos_q} + 33'(CHUNK_BYTES)) >= {1'b0, total_q};
        nx       = xbase_q + DIM_W'(tile_px);
        ny       = ybase_q + DIM_W'(TILE_ROWS);
        row_idx  = 32'(ybase_q) + 32'(line_y_q);
        pix_idx  = row_idx * 32'(xres_q) + 32'(xbase_q);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = empty ? ST_FINISH : ST_TBL_REQ;
            ST_TBL_REQ:  if (acc) state_d = ST_TBL_WAIT;
            ST_TBL_WAIT: if (ent_valid) state_d = linear_q ? ST_CHUNK : ST_LINE;
            ST_LINE: begin
                if (acc && tile_end) begin
                    if (nx >= xres_q && ny >= yres_q) state_d = ST_FINISH;
                    else                              state_d = ST_TBL_REQ;
                end
            end
            ST_CHUNK: begin
                if (acc) begin
                    if (lin_last)                   state_d = ST_FINISH;
                    else if (lin_off_q == LAST_OFF) state_d = ST_TBL_REQ;
                end
            end
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0; tile_addr_q <= '0; fb_pos_q <= '0; total_q <= '0;
            linear_q <= 1'b0; sh_q <= '0; xres_q <= '0; yres_q <= '0;
            xbase_q <= '0; ybase_q <= '0; tile_nr_q <= '0; lin_off_q <= '0;
            line_y_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    base_q    <= {frm_ctrl[31:9], 9'd0};
                    linear_q  <= frm_ctrl[1];
                    sh_q      <= sh_new;
                    xres_q    <= DIM_W'(xres);
                    yres_q    <= DIM_W'(yres);
                    total_q   <= (32'(xres) * 32'(yres)) << sh_new;
                    xbase_q   <= '0; ybase_q <= '0; tile_nr_q <= '0;
                    lin_off_q <= '0; fb_pos_q <= '0; line_y_q <= '0;
                end
                ST_TBL_WAIT: if (ent_valid) tile_addr_q <= {ent_data, 16'h0000};
                ST_LINE: if (acc) begin
                    if (!tile_end) line_y_q <= line_y_q + 8'd1;
                    else begin
                        line_y_q  <= '0;
                        tile_nr_q <= tile_nr_q + 16'd1;
                        if (nx >= xres_q) begin
                            xbase_q <= '0;
                            ybase_q <= ny;
                        end else begin
                            xbase_q <= nx;
                        end
                    end
                end
                ST_CHUNK: if (acc) begin
                    fb_pos_q <= fb_pos_q + 32'(CHUNK_BYTES);
                    if (lin_off_q == LAST_OFF) begin
                        lin_off_q <= '0;
                        tile_nr_q <= tile_nr_q + 16'd1;
                    end else begin
                        lin_off_q <= lin_off_q + 16'(CHUNK_BYTES);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_valid    = 1'b0;
        req_addr     = '0;
        req_len      = '0;
        req_dst      = '0;
        req_is_table = 1'b0;
        done         = 1'b0;
        unique case (state_q)
            ST_TBL_REQ: begin
                req_valid    = 1'b1;
                req_is_table = 1'b1;
                req_addr     = base_q + {15'd0, tile_nr_q, 1'b0};
                req_len      = LEN_W'(2);
            end
            ST_LINE: begin
                req_valid = 1'b1;
                req_addr  = tile_addr_q + (32'(line_y_q) << 9);
                req_len   = LEN_W'(pix) << sh_q;
                req_dst   = pix_idx << sh_q;
            end
            ST_CHUNK: begin
                req_valid = 1'b1;
                req_addr  = tile_addr_q + 32'(lin_off_q);
                req_len   = lin_last ? LEN_W'(total_q - fb_pos_q) : LEN_W'(CHUNK_BYTES);
                req_dst   = fb_pos_q;
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
            $stable(req_len) && $stable(req_dst) && $stable(req_is_table)));

    a_r1_table_len: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_table) |-> (req_len == LEN_W'(2)));

    a_r7_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_table) |-> (req_len != '0 && req_len <= LEN_W'(CHUNK_BYTES)));

    a_r4_line_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LINE && acc && !tile_end) |=>
            (req_valid && req_addr == $past(req_addr) + 32'd512));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid);
endmodule

// File: tb/tile_fetch_seq_bench.sv
module tile_fetch_seq_bench;
    localparam int XY_W  = 12;
    localparam int CHUNK = 16384;
    localparam int LEN_W = 17;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [31:0]      frm_ctrl = '0;
    logic [31:0]      plane_ctrl = '0;
    logic [XY_W-1:0]  xres = '0, yres = '0;
    logic             req_valid, req_is_table, done;
    logic             req_ready = 1'b0;
    logic [31:0]      req_addr, req_dst;
    logic [LEN_W-1:0] req_len;
    logic             ent_valid = 1'b0;
    logic [15:0]      ent_data = '0;

    always #10 clk = ~clk;

    tile_fetch_seq #(.XY_W(XY_W), .CHUNK_BYTES(CHUNK), .LEN_W(LEN_W)) u_tile_fetch_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .frm_ctrl(frm_ctrl),
        .plane_ctrl(plane_ctrl), .xres(xres), .yres(yres),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_dst(req_dst), .req_is_table(req_is_table),
        .ent_valid(ent_valid), .ent_data(ent_data), .done(done)
    );

    typedef struct {
        longint addr;
        longint len;
        longint dst;
        bit     tbl;
    } req_t;

    req_t exp_q[$];
    int   idx, checks, fails, cyc;
    bit   timed_out, trig, start_req;
    bit   pend_active;
    int   pend_cnt;
    logic [15:0] pend_data;
    int   tbl_n;

    function automatic logic [15:0] ent_of(int n);
        return 16'(16'h1200 + n * 7);
    endfunction

    function automatic int shift_of(logic [1:0] f);
        return (f == 2'd3) ? 2 : int'(f);
    endfunction

    task automatic push(longint a, longint l, longint d, bit t);
        req_t r;
        r.addr = a; r.len = l; r.dst = d; r.tbl = t;
        exp_q.push_back(r);
    endtask

    task automatic build_model();
        longint base, t, total, pos;
        int sh, xr, yr, xb, yb, tw, lines, pix, n;
        bit fin;
        exp_q.delete();
        base = longint'(frm_ctrl) & 64'hFFFF_FE00;
        xr = int'(xres); yr = int'(yres);
        sh = shift_of(plane_ctrl[14:13]);
        if (base == 0 || !frm_ctrl[0] || xr == 0 || yr == 0) return;
        n = 0; fin = 0;
        if (!frm_ctrl[1]) begin
            xb = 0; yb = 0; tw = 512 >> sh;
            while (!fin) begin
                push(base + 2 * n, 2, 0, 1);
                t = longint'(ent_of(n)) << 16;
                lines = (yr - yb < 128) ? yr - yb : 128;
                pix = (xr - xb < tw) ? xr - xb : tw;
                for (int y = 0; y < lines; y++)
                    push(t + 512 * y, pix << sh, (longint'(yb + y) * xr + xb) << sh, 0);
                xb += tw;
                if (xb >= xr) begin
                    xb = 0; yb += 128;
                    if (yb >= yr) fin = 1;
                end
                n++;
            end
        end else begin
            total = (longint'(xr) * yr) << sh; pos = 0;
            while (!fin) begin
                push(base + 2 * n, 2, 0, 1);
                t = longint'(ent_of(n)) << 16;
                for (int off = 0; off < 65536 && !fin; off += CHUNK) begin
                    if (pos + CHUNK >= total) begin
                        push(t + off, total - pos, pos, 0); fin = 1;
                    end else push(t + off, CHUNK, pos, 0);
                    pos += CHUNK;
                end
                n++;
            end
        end
    endtask

    task automatic cycle();
        bit exp_done;
        @(negedge clk);
        cyc++;
        if (cyc > 150000 && !timed_out) begin
            timed_out = 1; checks++; fails++;
            $display("FAIL watchdog: got hang expected finish");
        end
        exp_done = trig; trig = 0;
        if (done || exp_done) begin
            checks++;
            if (done !== exp_done) begin
                fails++;
                $display("FAIL R9 done timing: got %0b expected %0b", done, exp_done);
            end
        end
        ent_valid = 1'b0;
        if (pend_active) begin
            if (pend_cnt > 0) pend_cnt--;
            if (pend_cnt == 0) begin
                ent_valid = 1'b1; ent_data = pend_data; pend_active = 0;
            end
        end else if ($urandom % 6 == 0) begin
            ent_valid = 1'b1; ent_data = 16'($urandom); // R10 junk strobe
        end
        start = start_req;
        if (start_req && exp_q.size() == 0) trig = 1;
        start_req = 0;
        req_ready = ($urandom % 4) != 0;
        if (req_valid && req_ready) begin
            checks++;
            if (idx >= exp_q.size()) begin
                fails++;
                $display("FAIL R2 extra request: got addr %h expected none", req_addr);
            end else begin
                req_t e = exp_q[idx];
                if (req_addr !== 32'(e.addr) || req_len !== LEN_W'(e.len) ||
                    req_dst !== 32'(e.dst) || req_is_table !== e.tbl) begin
                    fails++;
                    $display("FAIL %s req %0d: got a=%h l=%0d d=%0d t=%0b expected a=%h l=%0d d=%0d t=%0b",
                        e.tbl ? "R1" : (frm_ctrl[1] ? "R6/R7" : "R4/R5"), idx,
                        req_addr, req_len, req_dst, req_is_table,
                        32'(e.addr), e.len, e.dst, e.tbl);
                end
                if (e.tbl) begin
                    pend_active = 1; pend_cnt = 1 + int'($urandom % 3);
                    pend_data = ent_of(tbl_n); tbl_n++;
                end
                idx++;
                if (idx == exp_q.size()) begin
                    trig = 1;
                    start = 1'b1; // R9 start collides with final acceptance
                end
            end
        end
    endtask

    task automatic run_frame(logic [31:0] fc, logic [1:0] dep, int xr, int yr);
        frm_ctrl = fc; plane_ctrl = 32'(dep) << 13;
        xres = XY_W'(xr); yres = XY_W'(yr);
        build_model();
        idx = 0; tbl_n = 0; pend_active = 0;
        start_req = 1;
        cycle();
        while (!timed_out && !(idx == exp_q.size() && !trig && !done)) cycle();
        for (int k = 0; k < 8 && !timed_out; k++) begin
            cycle();
            if (req_valid) begin
                checks++; fails++;
                $display("FAIL R9 request after frame: got valid=1 expected 0");
                break;
            end
        end
        checks++;
        if (idx != exp_q.size()) begin
            fails++;
            $display("FAIL R5 request count: got %0d expected %0d", idx, exp_q.size());
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        checks = 0; fails = 0; cyc = 0; timed_out = 0; trig = 0; start_req = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (req_valid !== 1'b0 || done !== 1'b0) begin
            fails++;
            $display("FAIL R8 reset state: got valid=%0b done=%0b expected 0 0", req_valid, done);
        end
        run_frame(32'h0000_0001, 2'd0, 64, 32);            // R2 zero base
        run_frame(32'h0040_0200, 2'd0, 64, 32);            // R2 fetch disabled
        run_frame(32'h0040_03F1, 2'd0, 640, 200);          // R4 R5 8bpp, right and bottom clip
        run_frame(32'h0040_0201, 2'd1, 300, 130);          // R3 16bpp
        run_frame(32'h0040_0201, 2'd2, 128, 128);          // R5 exact edges, 32bpp
        run_frame(32'h0040_0201, 2'd3, 100, 20);           // R3 field 3 as 4 bytes
        run_frame(32'h0040_0203, 2'd2, 300, 200);          // R6 linear across tiles
        run_frame(32'h0040_0203, 2'd0, 128, 256);          // R7 exact multiple
        run_frame(32'h0040_0203, 2'd1, 7, 3);              // R7 tiny frame
        for (int r = 0; r < 6 && !timed_out; r++)
            run_frame({9'd0, 14'($urandom | 1), 7'd0, 1'b0, 1'($urandom), 1'b1},
                      2'($urandom), 1 + int'($urandom % 400), 1 + int'($urandom % 260));
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule